// File: doc/BRIEF.md
# Quarter-Step Fractional Baud Tick Generator

This block turns the peripheral clock into the 16x oversample enable tick that paces a serial transmitter and receiver. Software supplies a 32-bit divider word. Bits 20:6 of that word form an unsigned step field. The oversample period is (4 + field) / 4 peripheral clocks, so the field selects a divisor in quarter-clock steps. The range runs from one tick every clock (field 0) to one tick every 8192.75 clocks (field 32767).

Inside, a phase accumulator counts in quarter-clock units. It gains four quarters on every clock. It emits a tick and keeps the excess whenever the sum reaches the period. This makes the average tick rate exactly 4/(4 + field) per clock, and any single tick lands within one clock of its ideal position. A divider write and a re-enable both restart the phase from zero, so a new rate starts cleanly. While the transmitter and the receiver are both disabled, the tick output stays low.

Top module: `frac_baud_gen`

## Requirements
- R1: A synchronous reset drives the tick low and sets the step field to 0. After reset, enabling either direction gives a tick on every clock.
- R2: Bits 5:0 of the divider word have no effect on the tick pattern.
- R3: The step field is taken from bits 20:6 of the divider word. Bits 31:21 have no effect.
- R4: Starting from a clean phase, exactly floor(4N / (4 + field)) ticks appear in the first N clock edges.
- R5: The gap between two consecutive ticks is always floor((4 + field)/4) or ceil((4 + field)/4) clocks.
- R6: The tick is low in the cycle after the edge that captures a divider write. The first tick follows ceil((4 + field)/4) edges after that capture edge.
- R7: When the field is 4 or more, a tick is never high for two consecutive cycles.
- R8: While tx_en and rx_en are both low, the tick is low from the next edge on and the phase is held at zero. A divider write made while the block is disabled is still captured.
- R9: Raising tx_en alone or rx_en alone restarts from a clean phase. The first tick then follows ceil((4 + field)/4) enabled edges.
- R10: The largest field, 32767, produces its first tick 8193 clocks after a clean start and averages one tick every 8192.75 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Write strobe for the divider word |
| div_wdata | input | 32 | Divider word; the step field is in bits 20:6 |
| tx_en | input | 1 | Transmitter enabled |
| rx_en | input | 1 | Receiver enabled |
| tick | output | 1 | One-clock oversample enable pulse |

## Verification
On every cycle, the embedded properties check the following. The accumulator stays below the period. Tick spacing stays within the floor/ceil bounds, measured by a gap counter. Ticks are single-cycle at field 4 and above. The tick is quiet after a write and while both directions are disabled. The exact tick counts over a window, the cycle of the first tick after a write or an enable, and the fact that the ignored divider bits really have no effect can only be shown by the bench scenarios, which compare against closed-form counts.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;

    // Width of the quarter-step field (covers divisors up to 8192.75 clocks)
    localparam int FIELD_W = 15;
    // Quarter units gained per peripheral clock
    localparam int QSTEP   = 4;
    // Accumulator width: holds period + QSTEP without wrap
    localparam int ACC_W   = FIELD_W + 2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [ACC_W-1:0]   acc_t;

    // Divider state handed from the capture register to the accumulator
    typedef struct packed {
        logic   restart;
        field_t field;
    } div_cmd_t;

    // Oversample period in quarter clocks
    function automatic acc_t period_q(input field_t f);
        return acc_t'(f) + acc_t'(QSTEP);
    endfunction

endpackage

// File: rtl/fbaud_div_reg.sv
module fbaud_div_reg
    import fbaud_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int FRAC_LSB = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output div_cmd_t         cmd
);

    localparam int FIELD_MSB = FRAC_LSB + FIELD_W - 1;

    field_t field_q;

    generate
        if (FIELD_MSB >= REG_W) begin : g_bad_width
            initial $error("divider field does not fit the register word");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (wr) begin
            field_q <= wdata[FIELD_MSB:FRAC_LSB];
        end
    end

    always_comb begin
        cmd.restart = wr;
        cmd.field   = field_q;
    end

endmodule

// File: rtl/fbaud_phase_acc.sv
module fbaud_phase_acc
    import fbaud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cmd_t cmd,
    input  logic     run,
    output logic     tick
);

    acc_t acc_q;
    acc_t period;
    acc_t sum;
    logic hit;
    logic tick_q;

    always_comb begin
        period = period_q(cmd.field);
        sum    = acc_q + acc_t'(QSTEP);
        hit    = (sum >= period);
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.restart || !run) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= hit;
            acc_q  <= hit ? (sum - period) : sum;
        end
    end

    assign tick = tick_q;

    // Gap counter: clocks since the last observed tick
    acc_t gap_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.restart || !run) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_q) begin
            gap_q  <= acc_t'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + acc_t'(1);
        end
    end

    // R4: residue always below the period
    p_acc_range_r4: assert property (@(posedge clk) disable iff (rst)
        acc_q < period);

    // R5: tick spacing within floor/ceil of period/4
    p_gap_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_q && seen_q) |->
            (gap_q >= (period >> 2)) && (gap_q <= ((period + acc_t'(3)) >> 2)));

    // R7: single-cycle pulse once the period reaches two clocks
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (tick_q && (period >= acc_t'(8)) && !cmd.restart) |=> !tick_q);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbaud_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int FRAC_LSB = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [REG_W-1:0] div_wdata,
    input  logic             tx_en,
    input  logic             rx_en,
    output logic             tick
);

    div_cmd_t cmd;
    logic     run;

    assign run = tx_en | rx_en;

    fbaud_div_reg #(
        .REG_W    (REG_W),
        .FRAC_LSB (FRAC_LSB)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (div_wr),
        .wdata (div_wdata),
        .cmd   (cmd)
    );

    fbaud_phase_acc u_acc (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .run  (run),
        .tick (tick)
    );

    // R6: capture edge of a write leaves the tick low
    p_wr_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !tick);

    // R8: both directions disabled keeps the tick low
    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        !(tx_en || rx_en) |=> !tick);

    // R1: reset leaves the tick low
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !tick);

endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;

    localparam real HALF = 2.5;
    localparam int  NV   = 8;
    localparam int unsigned VF [NV] = '{0, 1, 2, 3, 4, 5, 13, 100};
    localparam int  VN   = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        tx_en = 1'b0;
    logic        rx_en = 1'b0;
    logic        tick;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(HALF) clk = ~clk;

    frac_baud_gen dut (
        .clk       (clk),
        .rst       (rst),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .tick      (tick)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_div(input logic [31:0] v);
        @(posedge clk); #1;
        div_wr = 1'b1; div_wdata = v;
        @(posedge clk); #1;
        div_wr = 1'b0;
    endtask

    // Observe n edges; count ticks, first index, bad gaps, double-wide pulses
    task automatic run_window(input int p, input int n, output int cnt,
                              output int first, output int bad_gap, output int dbl);
        int last;
        bit prev;
        cnt = 0; first = 0; bad_gap = 0; dbl = 0; last = 0; prev = 0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #1;
            if (tick) begin
                cnt++;
                if (first == 0) first = i;
                else if ((i - last) < p / 4 || (i - last) > (p + 3) / 4) bad_gap++;
                last = i;
                if (prev) dbl++;
            end
            prev = tick;
        end
    endtask

    initial begin
        #(HALF * 2 * 190000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt, first, bg, dbl, p;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_eq("R1 tick in reset", int'(tick), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check_eq("R1 tick after reset", int'(tick), 0);
        rx_en = 1'b1;
        run_window(4, 5, cnt, first, bg, dbl);
        check_eq("R1 reset field gives every-clock tick", cnt, 5);

        // Vector table walk (R2 low bits vary, R4/R5/R6/R7)
        for (int v = 0; v < NV; v++) begin
            p = 4 + int'(VF[v]);
            write_div((VF[v] << 6) | ((v * 11 + 5) & 32'h3F));
            run_window(p, VN, cnt, first, bg, dbl);
            check_eq("R4 tick count", cnt, (4 * VN) / p);
            check_eq("R6 first tick edge", first, (p + 3) / 4);
            check_eq("R5 gap violations", bg, 0);
            if (VF[v] >= 4) check_eq("R7 double-wide pulses", dbl, 0);
        end

        // R2: low bits all ones, field 0
        write_div(32'h0000_003F);
        run_window(4, 8, cnt, first, bg, dbl);
        check_eq("R2 low bits ignored", cnt, 8);

        // R3: upper bits set, field 4
        write_div(32'hFFE0_0100);
        run_window(8, 20, cnt, first, bg, dbl);
        check_eq("R3 upper bits ignored count", cnt, 10);
        check_eq("R3 upper bits ignored first", first, 2);

        // R8: disable both, then write while disabled
        write_div(32'd13 << 6);
        @(posedge clk); #1;
        tx_en = 1'b0; rx_en = 1'b0;
        run_window(17, 30, cnt, first, bg, dbl);
        check_eq("R8 idle tick count", cnt, 0);
        write_div(32'd5 << 6);
        run_window(9, 20, cnt, first, bg, dbl);
        check_eq("R8 write while idle stays quiet", cnt, 0);

        // R9: tx only restarts clean, using field captured while idle
        tx_en = 1'b1;
        run_window(9, 45, cnt, first, bg, dbl);
        check_eq("R9 tx-only count", cnt, 20);
        check_eq("R9 tx-only first", first, 3);

        // R9: rx only after a pause mid-phase
        tx_en = 1'b0;
        run_window(9, 4, cnt, first, bg, dbl);
        rx_en = 1'b1;
        run_window(9, 45, cnt, first, bg, dbl);
        check_eq("R9 rx-only count", cnt, 20);
        check_eq("R9 rx-only first", first, 3);

        // R10: largest field
        write_div(32'd32767 << 6);
        run_window(32771, 16400, cnt, first, bg, dbl);
        check_eq("R10 max field first", first, 8193);
        check_eq("R10 max field count", cnt, (4 * 16400) / 32771);
        check_eq("R10 max field gaps", bg, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule